// File: doc/BRIEF.md
# Serial EEPROM Access Arbiter

This block lets software toggle the pins of an external one-bit serial EEPROM through a single control byte, while the memory port behind those pins is shared with other agents. Software writes the control byte with the request bit set. The block waits until the shared port reports no other activity, then takes ownership and raises the ready bit. While ownership is held, the stored chip-select, clock and data-out bits appear on the EEPROM pins and the data-in bit of the readback shows the EEPROM's serial output.

The ready bit has two roles. Its first rise after a request means the grant was won; that moment depends only on the other agents. After that, every write to the control byte clears ready, and ready comes back a fixed interval later (800 ns by default). Software bit-bangs the EEPROM protocol by writing, polling ready, and writing again. A write with the request bit clear gives the port back, drops ready and forces the pins low.

Top module: `ee_port_arb`

## Requirements
- R1: After reset the readback byte is 0x00 and chip-select, clock and data-out pins are low.
- R2: The request bit sits at bit 5 of both the write byte and the readback, and the readback bit 5 holds the value most recently written there.
- R3: While `port_busy` is high the grant is not given: ready (bit 4) stays 0 and all three EEPROM pins stay low, whatever control bits were written.
- R4: With a request pending, the first clock edge that sees `port_busy` low gives the grant, and ready reads 1 from that edge on with no pacing delay.
- R5: While the grant is held, `ee_cs`, `ee_sck` and `ee_mosi` equal write bits 3, 2 and 1 of the latest write.
- R6: Readback bit 0 equals `ee_miso` while the grant is held and reads 0 otherwise.
- R7: A write with bit 5 set during the grant clears ready at that clock edge; ready rises again exactly PACE_CYCLES edges after the write edge, where PACE_CYCLES is DELAY_NS divided by the clock period, rounded up.
- R8: A second write before the interval expires restarts the full interval from the second write.
- R9: A write with bit 5 clear releases the grant: ready and bit 5 read 0 and all three pins go low, and a later request starts a fresh arbitration whose grant again shows ready with no pacing delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: bit 5 request, bits 3..1 chip-select, clock, data-out |
| rd_data | output | 8 | Readback: bit 5 request, bit 4 ready, bits 3..1 pin values, bit 0 data-in |
| port_busy | input | 1 | High while another agent uses the shared port |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | EEPROM serial data toward the device |
| ee_miso | input | 1 | EEPROM serial data from the device |

## Verification
The assertions take for granted that `port_busy` and `wr_en` are synchronous to `clk` and settle before each rising edge, and that `port_busy` only matters while a request waits: once the grant is held the other agents are assumed to stay off the port. The stimulus changes every input on the falling edge, lowers `port_busy` only while a request waits, and leaves it low for the whole time ownership is held, so the pacing interval is measured from clean write edges.

// File: rtl/ee_port_pkg.sv
package ee_port_pkg;

    localparam int REG_W   = 8;
    localparam int B_REQ   = 5;
    localparam int B_READY = 4;
    localparam int B_CS    = 3;
    localparam int B_SCK   = 2;
    localparam int B_MOSI  = 1;
    localparam int B_MISO  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic req;
        logic cs;
        logic sck;
        logic mosi;
    } ctl_t;

    function automatic int unsigned pace_cycles(input int unsigned delay_ns,
                                                input int unsigned period_ps);
        return (delay_ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input ctl_t c,
                                                     input logic ready,
                                                     input logic din);
        logic [REG_W-1:0] v;
        v          = '0;
        v[B_REQ]   = c.req;
        v[B_READY] = ready;
        v[B_CS]    = c.cs;
        v[B_SCK]   = c.sck;
        v[B_MOSI]  = c.mosi;
        v[B_MISO]  = din;
        return v;
    endfunction

endpackage

// File: rtl/ee_arb_fsm.sv
module ee_arb_fsm
    import ee_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_wr,
    input  logic req_val,
    input  logic port_busy,
    output logic owned
);

    arb_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (req_wr && !req_val) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_wr && req_val) st_d = ST_WAIT;
                ST_WAIT: if (!port_busy)        st_d = ST_OWN;
                ST_OWN:  st_d = ST_OWN;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign owned = (st_q == ST_OWN);

    // R3: the port is never taken while another agent holds it
    p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && port_busy && !req_wr) |=> (st_q == ST_WAIT));

    // R9: a write with the request bit clear always returns to idle
    p_release_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (req_wr && !req_val) |=> (st_q == ST_IDLE));

    // R4: ownership is only entered from the waiting state
    p_grant_from_wait_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(owned) |-> ($past(st_q) == ST_WAIT && !$past(port_busy)));

endmodule

// File: rtl/ee_pace_timer.sv
module ee_pace_timer #(
    parameter int unsigned PACE_CYCLES = 200,
    localparam int CNT_W = $clog2(PACE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic expired
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PACE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)       cnt_q <= '0;
        else if (load)          cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R7: the interval counts down one step per cycle unless restarted
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !load && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: a restart always reloads the full interval
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/ee_port_arb.sv
module ee_port_arb
    import ee_port_pkg::*;
#(
    parameter int unsigned DELAY_NS      = 800,
    parameter int unsigned CLK_PERIOD_PS = 4000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             port_busy,
    output logic             ee_cs,
    output logic             ee_sck,
    output logic             ee_mosi,
    input  logic             ee_miso
);

    localparam int unsigned PACE_CYCLES = pace_cycles(DELAY_NS, CLK_PERIOD_PS);

    ctl_t ctl_q, ctl_wr;
    logic owned, expired, ready, pace_load;
    logic unused_wr_bits;

    assign ctl_wr.req  = wr_data[B_REQ];
    assign ctl_wr.cs   = wr_data[B_CS];
    assign ctl_wr.sck  = wr_data[B_SCK];
    assign ctl_wr.mosi = wr_data[B_MOSI];
    assign unused_wr_bits = ^{wr_data[7:6], wr_data[B_READY], wr_data[B_MISO]};

    always_ff @(posedge clk) begin
        if (rst)        ctl_q <= '0;
        else if (wr_en) ctl_q <= ctl_wr;
    end

    ee_arb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_wr    (wr_en),
        .req_val   (ctl_wr.req),
        .port_busy (port_busy),
        .owned     (owned)
    );

    assign pace_load = wr_en && ctl_wr.req && owned;

    ee_pace_timer #(.PACE_CYCLES(PACE_CYCLES)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .clear   (!owned),
        .load    (pace_load),
        .expired (expired)
    );

    assign ready   = owned && expired;
    assign ee_cs   = owned && ctl_q.cs;
    assign ee_sck  = owned && ctl_q.sck;
    assign ee_mosi = owned && ctl_q.mosi;
    assign rd_data = pack_status(ctl_q, ready, owned && ee_miso);

    // R3 / R9: pins stay quiet whenever the port is not owned
    p_pins_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_data[B_READY] && !owned |-> (!ee_cs && !ee_sck && !ee_mosi));

    // R7: a paced write removes ready on the next cycle
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (owned && wr_en && wr_data[B_REQ]) |=> !rd_data[B_READY]);

    // R5: once owned, the pins track the last written control bits
    p_pins_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (owned && wr_en && wr_data[B_REQ]) |=>
            (ee_cs == $past(wr_data[B_CS]) && ee_sck == $past(wr_data[B_SCK])
             && ee_mosi == $past(wr_data[B_MOSI])));

endmodule

// File: tb/sim_ee_port_arb.sv
module sim_ee_port_arb;

    localparam int PACE = 800 * 1000 / 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       port_busy = 1'b0;
    logic       ee_cs, ee_sck, ee_mosi;
    logic       ee_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ee_port_arb u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .port_busy(port_busy), .ee_cs(ee_cs),
        .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pins();
        return {5'd0, ee_cs, ee_sck, ee_mosi};
    endfunction

    task automatic t_reset();
        chk("R1 readback", rd_data, 8'h00);
        chk("R1 pins", pins(), 8'h00);
    endtask

    task automatic t_busy_hold();
        port_busy = 1'b1;
        ee_miso = 1'b1;
        write_reg(8'h2E);
        chk("R2 request bit", {7'd0, rd_data[5]}, 8'h01);
        repeat (6) @(negedge clk);
        chk("R3 ready held off", {7'd0, rd_data[4]}, 8'h00);
        chk("R3 pins low", pins(), 8'h00);
        chk("R6 din masked", {7'd0, rd_data[0]}, 8'h00);
    endtask

    task automatic t_grant();
        port_busy = 1'b0;
        @(negedge clk);
        chk("R4 ready on grant", {7'd0, rd_data[4]}, 8'h01);
        chk("R5 pins after grant", pins(), 8'h07);
        chk("R6 din high", {7'd0, rd_data[0]}, 8'h01);
        ee_miso = 1'b0;
        #1;
        chk("R6 din low", {7'd0, rd_data[0]}, 8'h00);
    endtask

    task automatic t_pace();
        write_reg(8'h28);
        chk("R7 ready drops", {7'd0, rd_data[4]}, 8'h00);
        chk("R5 pins cs only", pins(), 8'h04);
        repeat (PACE - 1) @(negedge clk);
        chk("R7 ready still low", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        chk("R7 ready back", {7'd0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_restart();
        write_reg(8'h2C);
        repeat (100) @(negedge clk);
        write_reg(8'h22);
        chk("R5 pins mosi only", pins(), 8'h01);
        repeat (PACE - 1) @(negedge clk);
        chk("R8 restarted interval", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        chk("R8 ready after restart", {7'd0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_release();
        write_reg(8'h2A);
        write_reg(8'h0E);
        ee_miso = 1'b1;
        #1;
        chk("R9 readback after release", rd_data, 8'h0E);
        chk("R9 pins low", pins(), 8'h00);
        write_reg(8'h24);
        @(negedge clk);
        chk("R9 fresh grant ready", {7'd0, rd_data[4]}, 8'h01);
        chk("R9 fresh grant pins", pins(), 8'h02);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_busy_hold();
                t_grant();
                t_pace();
                t_restart();
                t_release();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule